// File: doc/BRIEF.md
# Byte-Register Serial Port Front End

This block connects a processor's simple register bus to a minimal serial transmitter and to an external receive queue. The processor sees eight byte-wide registers on word-aligned addresses. Four constant identification bytes come first. After them are a data register, a single register that holds both status and control, and the two halves of a 16-bit baud divisor. Writing the data register places one character into a one-deep holding register. A shifter then sends it on the line as 8N1: a low start bit, eight data bits with the least significant bit first, and one high stop bit.

Reading the data register removes one byte from the receive queue. The queue sits outside the block and offers a valid/pop interface, two fill-level flags and two error pulses. The block produces a quarter-bit tick from the divisor, so one bit lasts four divisor periods. A single interrupt output covers two cases: receive data or a receive error is waiting, and the transmitter has room for another character.

Top module: `serial_byte_port`

## Requirements
- R1: Register index is bus address bits [4:2], and an access is taken only when bits [1:0] are zero. Indexes 0..3 read bytes 0..3 of the parameter ID_WORD, where index 0 is the least significant byte. Index 4 is data, index 5 is status, index 6 is the divisor low byte and index 7 is the divisor high byte. Both divisor bytes read back what was written. Read data appears on bus_rdata one clock after the access and holds until the next read.
- R2: With divisor value D, every bit on tx_line lasts exactly 4*(D+1) clock cycles. A character moves from the holding register to the shifter only on a tick, so the start bit also has the full bit length.
- R3: Each frame on tx_line is one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line idles high.
- R4: Status bit 7 (transmit empty) is 1 when the holding register is free. A data write clears it, and it returns to 1 when the character moves into the shifter. A data write made while it is 0 is ignored.
- R5: A data read while rx_valid is 1 asserts rx_pop in that cycle and returns rx_data. A data read while rx_valid is 0 returns the last popped byte and does not assert rx_pop.
- R6: Status bits 3 (receive full, follows rx_full), 4 (one slot left, follows rx_one_left), 5 (receive empty, equals not rx_valid) and 7 are read-only. Writes to these bits have no effect.
- R7: Status bit 0 (frame error) and bit 1 (overrun) are sticky. A pulse on rx_frame_err or rx_overrun sets them. A status write with the bit at 0 clears it, and a status write with the bit at 1 keeps it as it was and never sets it.
- R8: Status bit 2 is the receive interrupt enable and bit 6 is the transmit interrupt enable, both written through the status register. irq equals (bit 2 AND (rx_valid OR frame error OR overrun)) OR (bit 6 AND transmit empty).
- R9: After reset, both enables are 0, both error bits are 0, transmit empty is 1, tx_line is high and irq is low.
- R10: A receive error raises irq while the receive interrupt is enabled, even when no data byte is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Receive queue holds a byte |
| rx_data | input | 8 | Byte at the head of the receive queue |
| rx_full | input | 1 | Receive queue full |
| rx_one_left | input | 1 | Receive queue has one free slot |
| rx_frame_err | input | 1 | Pulse: a stop bit was missing |
| rx_overrun | input | 1 | Pulse: a byte arrived while the queue was full |
| rx_pop | output | 1 | Remove the head byte from the receive queue |
| tx_line | output | 1 | Serial output |
| irq | output | 1 | Combined interrupt |

## Verification
Some rules are checked by assertions on every cycle:
- tx_line changes only after a quarter-bit tick.
- rx_pop never fires without a valid byte.
- An accepted data write always fills the holding register.
- An error bit never rises except from a receive pulse.
- An enabled, empty transmitter always raises irq.

Other behaviour can only be shown by the bench's scenarios, using a serial decoder and a scoreboard of expected characters:
- the exact bit length under two divisor values;
- bit order and the stop bit;
- that a write to a full holding register is dropped;
- that a read of an empty queue returns the old byte;
- the full interrupt equation.

// File: rtl/sbp_pkg.sv
// Shared constants for the byte-register serial port: register indexes,
// status bit positions and widths. Assumes 8-bit registers on 4-byte strides.
package sbp_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_AW = 5;
    localparam int DIV_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        IDX_ID0   = 3'd0,
        IDX_ID1   = 3'd1,
        IDX_ID2   = 3'd2,
        IDX_ID3   = 3'd3,
        IDX_DATA  = 3'd4,
        IDX_STAT  = 3'd5,
        IDX_DIVLO = 3'd6,
        IDX_DIVHI = 3'd7
    } reg_idx_e;

    localparam int ST_FERR  = 0;
    localparam int ST_OERR  = 1;
    localparam int ST_RXIE  = 2;
    localparam int ST_RXFUL = 3;
    localparam int ST_RXONE = 4;
    localparam int ST_RXEMP = 5;
    localparam int ST_TXIE  = 6;
    localparam int ST_TXEMP = 7;
endpackage

// File: rtl/sbp_baud_gen.sv
// Quarter-bit tick generator. A down-counter reloads from the divisor, so a
// tick occurs every divisor+1 cycles. A new divisor takes effect at the next reload.
module sbp_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    // Count down and reload on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= divisor;
        else           cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/sbp_tx_shift.sv
// One-character holding register feeding an 8N1 shifter. Assumes TPB >= 2
// ticks per bit. A character is taken only on a tick while the shifter is idle,
// so every bit, including the start bit, is TPB ticks long.
module sbp_tx_shift #(
    parameter int DATA_W = 8,
    parameter int TPB    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hold_empty,
    output logic              line
);
    localparam int SUB_W = $clog2(TPB);
    localparam int CNT_W = $clog2(DATA_W + 2);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              busy;
    logic [DATA_W:0]   shreg;
    logic [SUB_W-1:0]  sub_cnt;
    logic [CNT_W-1:0]  bit_cnt;
    logic              take;

    assign take       = tick && !busy && hold_full;
    assign hold_empty = !hold_full;

    // Holding register: fills on a write when free, empties when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (wr_en && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end
    end

    // Shifter: start bit, data bits LSB first, then the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            line    <= 1'b1;
            shreg   <= '1;
            sub_cnt <= '0;
            bit_cnt <= '0;
        end else if (take) begin
            busy    <= 1'b1;
            line    <= 1'b0;
            shreg   <= {1'b1, hold_data};
            sub_cnt <= '0;
            bit_cnt <= '0;
        end else if (tick && busy) begin
            if (sub_cnt == SUB_W'(TPB - 1)) begin
                sub_cnt <= '0;
                if (bit_cnt == CNT_W'(DATA_W + 1)) begin
                    busy <= 1'b0;
                end else begin
                    line    <= shreg[0];
                    shreg   <= {1'b1, shreg[DATA_W:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else begin
                sub_cnt <= sub_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbp_status.sv
// Writable part of the status register: two interrupt enables and two sticky
// error bits. A write clears an error bit written as 0. A receive pulse sets it,
// and the pulse wins over a write in the same cycle.
module sbp_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       set_ferr,
    input  logic       set_oerr,
    output logic       rx_ie,
    output logic       tx_ie,
    output logic       ferr,
    output logic       oerr
);
    import sbp_pkg::*;

    // Enables follow the written value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ie <= 1'b0;
            tx_ie <= 1'b0;
        end else if (wr_en) begin
            rx_ie <= wdata[ST_RXIE];
            tx_ie <= wdata[ST_TXIE];
        end
    end

    // Sticky errors: set by pulses, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ferr <= 1'b0;
            oerr <= 1'b0;
        end else begin
            ferr <= set_ferr || (ferr && !(wr_en && !wdata[ST_FERR]));
            oerr <= set_oerr || (oerr && !(wr_en && !wdata[ST_OERR]));
        end
    end
endmodule

// File: rtl/serial_byte_port.sv
// Bus front end of the byte-register serial port. Decodes word-aligned
// accesses, registers read data, pops the external receive queue on data reads,
// holds the baud divisor and forms the combined interrupt.
// Assumes single-cycle bus strobes.
module serial_byte_port #(
    parameter logic [31:0] ID_WORD   = 32'h5A17_C301,
    parameter logic [15:0] DIV_RESET = 16'd1,
    parameter int          TPB       = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_we,
    input  logic [sbp_pkg::REG_AW-1:0] bus_addr,
    input  logic [sbp_pkg::BYTE_W-1:0] bus_wdata,
    output logic [sbp_pkg::BYTE_W-1:0] bus_rdata,
    input  logic                       rx_valid,
    input  logic [sbp_pkg::BYTE_W-1:0] rx_data,
    input  logic                       rx_full,
    input  logic                       rx_one_left,
    input  logic                       rx_frame_err,
    input  logic                       rx_overrun,
    output logic                       rx_pop,
    output logic                       tx_line,
    output logic                       irq
);
    import sbp_pkg::*;

    reg_idx_e          idx;
    logic              aligned, rd_en, wr_en;
    logic [BYTE_W-1:0] last_rx, rd_val, status;
    logic [DIV_W-1:0]  divisor;
    logic              baud_tick, tx_empty, rx_ie, tx_ie, ferr, oerr;
    logic              wr_data_reg, wr_stat_reg;

    assign idx         = reg_idx_e'(bus_addr[4:2]);
    assign aligned     = (bus_addr[1:0] == 2'b00);
    assign rd_en       = bus_sel && !bus_we && aligned;
    assign wr_en       = bus_sel && bus_we && aligned;
    assign wr_data_reg = wr_en && (idx == IDX_DATA);
    assign wr_stat_reg = wr_en && (idx == IDX_STAT);
    assign rx_pop      = rd_en && (idx == IDX_DATA) && rx_valid;

    sbp_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(baud_tick)
    );

    sbp_tx_shift #(.DATA_W(BYTE_W), .TPB(TPB)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .wr_en(wr_data_reg),
        .wr_data(bus_wdata), .hold_empty(tx_empty), .line(tx_line)
    );

    sbp_status u_stat (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_stat_reg), .wdata(bus_wdata),
        .set_ferr(rx_frame_err), .set_oerr(rx_overrun),
        .rx_ie(rx_ie), .tx_ie(tx_ie), .ferr(ferr), .oerr(oerr)
    );

    // Assemble the status byte from live flags and stored bits.
    always_comb begin
        status           = '0;
        status[ST_FERR]  = ferr;
        status[ST_OERR]  = oerr;
        status[ST_RXIE]  = rx_ie;
        status[ST_RXFUL] = rx_full;
        status[ST_RXONE] = rx_one_left;
        status[ST_RXEMP] = !rx_valid;
        status[ST_TXIE]  = tx_ie;
        status[ST_TXEMP] = tx_empty;
    end

    // Select the value returned by a read.
    always_comb begin
        case (idx)
            IDX_DATA:  rd_val = rx_valid ? rx_data : last_rx;
            IDX_STAT:  rd_val = status;
            IDX_DIVLO: rd_val = divisor[BYTE_W-1:0];
            IDX_DIVHI: rd_val = divisor[DIV_W-1:BYTE_W];
            default:   rd_val = ID_WORD[{bus_addr[3:2], 3'b000} +: BYTE_W];
        endcase
    end

    // Register read data and remember the last popped byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            last_rx   <= '0;
        end else begin
            if (rd_en)  bus_rdata <= rd_val;
            if (rx_pop) last_rx   <= rx_data;
        end
    end

    // Divisor bytes, written separately.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divisor <= DIV_RESET;
        end else if (wr_en && idx == IDX_DIVLO) begin
            divisor[BYTE_W-1:0] <= bus_wdata;
        end else if (wr_en && idx == IDX_DIVHI) begin
            divisor[DIV_W-1:BYTE_W] <= bus_wdata;
        end
    end

    // Combined receive and transmit interrupt.
    assign irq = (rx_ie && (rx_valid || ferr || oerr)) || (tx_ie && tx_empty);
endmodule

// File: rtl/serial_byte_port_chk.sv
// Assertion checker for serial_byte_port, attached with bind. It observes
// internal ticks, enables and error bits and makes no changes to the design.
module serial_byte_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       tx_line,
    input logic       rx_pop,
    input logic       rx_valid,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [4:0] bus_addr,
    input logic       tx_empty,
    input logic       ferr,
    input logic       oerr,
    input logic       rx_frame_err,
    input logic       rx_overrun,
    input logic       tx_ie,
    input logic       irq
);
    // R2: the line moves only after a quarter-bit tick
    p_line_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tx_line));

    // R5: no pop without a valid byte
    p_pop_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> rx_valid);

    // R4: an accepted data write fills the holding register
    p_write_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 5'd16 && tx_empty) |=> !tx_empty);

    // R7: error bits rise only from receive pulses
    p_ferr_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ferr && !rx_frame_err) |=> !ferr);
    p_oerr_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!oerr && !rx_overrun) |=> !oerr);

    // R8: enabled and empty transmitter requests an interrupt
    p_tx_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie && tx_empty) |-> irq);
endmodule

bind serial_byte_port serial_byte_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .tx_line(tx_line),
    .rx_pop(rx_pop), .rx_valid(rx_valid), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .tx_empty(tx_empty), .ferr(ferr), .oerr(oerr),
    .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun), .tx_ie(tx_ie),
    .irq(irq)
);

// File: tb/serial_byte_port_bench.sv
// Scoreboard bench: send_byte pushes expected characters into a queue and a
// serial monitor decodes tx_line, then pops and compares. Register checks are inline.
module serial_byte_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0, rx_full = 1'b0, rx_one_left = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_frame_err = 1'b0, rx_overrun = 1'b0;
    logic       rx_pop, tx_line, irq;

    int n_checks = 0;
    int n_fails  = 0;
    int bit_cyc  = 8;
    bit done     = 1'b0;
    logic [7:0] exp_q[$];
    logic pop_seen;
    logic [7:0] rv;

    always #10 clk = ~clk;

    serial_byte_port u_serial_byte_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_full(rx_full),
        .rx_one_left(rx_one_left), .rx_frame_err(rx_frame_err),
        .rx_overrun(rx_overrun), .rx_pop(rx_pop), .tx_line(tx_line), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 pop_seen = rx_pop;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_err(input bit frame);
        @(negedge clk);
        if (frame) rx_frame_err = 1'b1; else rx_overrun = 1'b1;
        @(negedge clk);
        rx_frame_err = 1'b0; rx_overrun = 1'b0;
    endtask

    // Driver: wait for room, write the character, record it as expected.
    task automatic send_byte(input logic [7:0] b);
        logic [7:0] s;
        s = 8'h00;
        while (!s[7]) bus_rd(5'd20, s);
        bus_wr(5'd16, b);
        exp_q.push_back(b);
    endtask

    // Monitor: decode frames at mid-bit and compare with the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_line == 1'b0) begin
                int b;
                logic [7:0] got;
                logic stop_b, start_end, after_start, exp_b;
                b = bit_cyc;
                got = '0; stop_b = 1'b0; start_end = 1'b1; after_start = 1'b0;
                for (int off = 1; off <= 9 * b + b / 2; off++) begin
                    @(negedge clk);
                    if (off == b - 1) start_end = tx_line;
                    if (off == b) after_start = tx_line;
                    for (int i = 0; i < 8; i++)
                        if (off == (i + 1) * b + b / 2) got[i] = tx_line;
                    if (off == 9 * b + b / 2) stop_b = tx_line;
                end
                if (exp_q.size() == 0) begin
                    n_checks++; n_fails++;
                    $display("FAIL R4 unexpected frame actual=%02h expected=none", got);
                end else begin
                    exp_b = exp_q[0][0];
                    chk("R3 frame data", got, exp_q.pop_front());
                    chk("R3 stop bit", {7'd0, stop_b}, 8'd1);
                    chk("R2 start bit full length", {7'd0, start_end}, 8'd0);
                    chk("R2 start bit not too long", {7'd0, after_start}, {7'd0, exp_b});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 line idle", {7'd0, tx_line}, 8'd1);
        chk("R9 irq low", {7'd0, irq}, 8'd0);
        bus_rd(5'd20, rv); chk("R9 status after reset", rv, 8'hA0);

        // R1 ID bytes, divisor read-back and misaligned access
        bus_rd(5'd0, rv);  chk("R1 ID0", rv, 8'h01);
        bus_rd(5'd4, rv);  chk("R1 ID1", rv, 8'hC3);
        bus_rd(5'd8, rv);  chk("R1 ID2", rv, 8'h17);
        bus_rd(5'd12, rv); chk("R1 ID3", rv, 8'h5A);
        bus_rd(5'd24, rv); chk("R1 divisor low reset", rv, 8'h01);
        bus_wr(5'd28, 8'h00);
        bus_wr(5'd25, 8'h77);
        bus_rd(5'd24, rv); chk("R1 misaligned write ignored", rv, 8'h01);
        bus_rd(5'd28, rv); chk("R1 divisor high", rv, 8'h00);

        // R3 R2 frames with divisor 1: bit is 8 cycles
        bit_cyc = 8;
        send_byte(8'h55); send_byte(8'hA3); send_byte(8'hFF);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2 * bit_cyc) @(negedge clk);

        // R2 divisor 3: bit is 16 cycles
        bus_wr(5'd24, 8'h03);
        bit_cyc = 16;
        repeat (8) @(negedge clk);
        send_byte(8'h0F); send_byte(8'h80);

        // R4 holding register: second write while full is dropped
        send_byte(8'h3C);
        bus_rd(5'd20, rv);
        while (!rv[7]) bus_rd(5'd20, rv);
        bus_wr(5'd16, 8'hE1); exp_q.push_back(8'hE1);
        bus_wr(5'd16, 8'h11);
        bus_rd(5'd20, rv); chk("R4 tx empty clear while holding", {7'd0, rv[7]}, 8'd0);
        // R8 transmit interrupt gated by empty
        bus_wr(5'd20, 8'h40);
        @(negedge clk);
        chk("R8 tx irq low while holding full", {7'd0, irq}, 8'd0);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2 * bit_cyc) @(negedge clk);
        chk("R8 tx irq when empty", {7'd0, irq}, 8'd1);
        bus_wr(5'd20, 8'h00);
        @(negedge clk);
        chk("R8 irq off when disabled", {7'd0, irq}, 8'd0);

        // R5 data reads and popping
        rx_valid = 1'b1; rx_data = 8'h9E;
        bus_rd(5'd20, rv); chk("R6 rx empty low with data", {7'd0, rv[5]}, 8'd0);
        bus_rd(5'd16, rv);
        chk("R5 read data", rv, 8'h9E);
        chk("R5 pop on read", {7'd0, pop_seen}, 8'd1);
        rx_valid = 1'b0; rx_data = 8'h42;
        bus_rd(5'd16, rv);
        chk("R5 empty read returns last", rv, 8'h9E);
        chk("R5 no pop when empty", {7'd0, pop_seen}, 8'd0);

        // R6 read-only flags
        rx_full = 1'b1; rx_one_left = 1'b1;
        bus_wr(5'd20, 8'h00);
        bus_rd(5'd20, rv); chk("R6 flags track inputs, write ignored", rv, 8'hB8);
        rx_full = 1'b0; rx_one_left = 1'b0;
        bus_wr(5'd20, 8'hB8);
        bus_rd(5'd20, rv); chk("R6 writing flag ones ignored", rv, 8'hA0);

        // R7 sticky errors
        bus_wr(5'd20, 8'h03);
        bus_rd(5'd20, rv); chk("R7 writing 1 does not set", rv[1:0], 2'b00);
        pulse_err(1'b1);
        bus_rd(5'd20, rv); chk("R7 frame error set", rv[1:0], 2'b01);
        bus_wr(5'd20, 8'h01);
        bus_rd(5'd20, rv); chk("R7 write 1 keeps", rv[1:0], 2'b01);
        bus_wr(5'd20, 8'h00);
        bus_rd(5'd20, rv); chk("R7 write 0 clears", rv[1:0], 2'b00);
        pulse_err(1'b0);
        bus_rd(5'd20, rv); chk("R7 overrun set", rv[1:0], 2'b10);

        // R10 error interrupt with no data; R8 receive interrupt
        bus_wr(5'd20, 8'h06);
        @(negedge clk);
        chk("R10 irq on error without data", {7'd0, irq}, 8'd1);
        bus_wr(5'd20, 8'h04);
        @(negedge clk);
        chk("R8 irq low, no data, no error", {7'd0, irq}, 8'd0);
        rx_valid = 1'b1;
        #1 chk("R8 irq on receive data", {7'd0, irq}, 8'd1);
        rx_valid = 1'b0;
        pulse_err(1'b1);
        chk("R10 irq on frame error", {7'd0, irq}, 8'd1);
        bus_wr(5'd20, 8'h04);
        @(negedge clk);
        chk("R7 cleared error drops irq", {7'd0, irq}, 8'd0);

        // Final drain: no frame may follow
        repeat (12 * bit_cyc) @(negedge clk);
        chk("R4 scoreboard drained", 8'(exp_q.size()), 8'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule